// File: doc/BRIEF.md
# Analog-Shared GPIO Port Controller

An eight-pin general-purpose I/O port whose pins are also claimed by an analog converter and by a wake-up interrupt function. Software sees four registers on a simple single-cycle bus: the output data latch, the per-pin direction, the per-pin wake-up enable and the sticky wake-up flags. The converter side supplies two masks: which pins it currently owns and which pins have their digital input buffer switched on.

Each pin is resolved every cycle. The converter has first claim on a pin, then the wake-up logic (a pin with its wake enable set), then plain GPIO. A converter-owned pin never drives and never raises a wake flag. Pin levels pass through a two-flop synchronizer before they reach the readback path or the falling-edge detector. A pin whose input buffer is off reads as logic one and cannot produce an edge.

Top module: `anport_ctrl`

## Requirements
- R1: After reset `pad_oe` is 0, the direction, wake-enable and flag registers read 0, `wake_irq` is 0 and the data latch holds 0.
- R2: A bus write to address 0 (data) always updates the latch, which appears on `pad_out`. `pad_oe[i]` is 1 only when direction bit i is 1 and the converter does not own pin i.
- R3: A read of address 0 returns the latch bit for every pin whose direction bit is 1.
- R4: A read of address 0 returns 1 for every pin with direction 0 and `dig_in_en` 0.
- R5: A read of address 0 returns the synchronized pin level for every pin with direction 0 and `dig_in_en` 1. A change on `pad_in` becomes visible after the second rising edge and not after the first.
- R6: While `conv_own[i]` is 1, pin i has `pad_oe[i]` at 0 and its wake flag cannot set, whatever the direction and wake-enable bits hold.
- R7: Wake flag i sets on a falling edge of the synchronized pin i when wake enable i is 1, `dig_in_en[i]` is 1 and the converter does not own the pin. It is readable after the third rising edge from the pin change. A pin with `dig_in_en` 0 never sets its flag.
- R8: Writing 1 to a bit of address 3 (flags) clears that flag, and writing 0 leaves it unchanged. When a new edge and a clear of the same bit fall in the same cycle, the flag stays set.
- R9: `wake_irq` is 1 exactly when some flag bit is set together with its wake-enable bit.
- R10: Address 1 (direction) and address 2 (wake enable) can be written and read back at any time. Bit i of every register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 wake enable, 3 wake flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| conv_own | input | 8 | Pins currently claimed by the analog converter |
| dig_in_en | input | 8 | Per-pin digital input buffer enable from the converter side |
| pad_in | input | 8 | Pin levels, asynchronous |
| pad_out | output | 8 | Output data towards the pads |
| pad_oe | output | 8 | Per-pin output enable |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
A software write-one-to-clear of a wake flag and a fresh falling edge on the same pin can land on the same rising edge. That case sets the flag updater's set and clear terms against each other. The bench first sets a flag, raises the pin again and then lowers it. It times the clear write so that its strobe shares the rising edge on which the synchronized edge is detected. The flag must then read 1, and a second clear with no edge must bring it to 0. Converter ownership is also changed while wake edges are pending, to check that claimed pins drop out of both drive and flagging.

// File: rtl/anport_pkg.sv
// Shared register map for the analog-shared GPIO port.
package anport_pkg;
    typedef enum logic [1:0] {
        RA_DATA   = 2'd0,
        RA_DIR    = 2'd1,
        RA_WKEN   = 2'd2,
        RA_WKFLAG = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/anport_regs.sv
// Register file: data latch, direction and wake enable, plus the decoded
// write-one-to-clear mask for the flag register held elsewhere.
// Assumes a single-cycle write strobe; reads are handled by the top level.
module anport_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] wken_q,
    output logic [NPINS-1:0] clr_mask
);
    import anport_pkg::*;

    // Register updates on bus writes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            wken_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                RA_DATA: data_q <= reg_wdata;
                RA_DIR:  dir_q  <= reg_wdata;
                RA_WKEN: wken_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Flag clear mask, valid only during a write to the flag address.
    always_comb begin
        clr_mask = (reg_wr && reg_addr_e'(reg_addr) == RA_WKFLAG) ? reg_wdata : '0;
    end

    // R2: a data write lands in the latch regardless of direction.
    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (data_q == $past(reg_wdata)));

    // R1: control registers come out of reset cleared.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (dir_q == '0 && wken_q == '0 && data_q == '0));
endmodule

// File: rtl/anport_sync.sv
// Multi-flop synchronizer for the asynchronous pin levels.
// Resets to all ones so that no falling edge appears on leaving reset.
module anport_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] async_in,
    output logic [NPINS-1:0] sync_out
);
    logic [NPINS-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One synchronizer stage; the first samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '1;
                else if (s == 0)
                    chain[s] <= async_in;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/anport_wake.sv
// Wake-up edge detection and sticky flags. A pin qualifies when the
// converter does not own it, its wake enable is set and its digital input
// buffer is on. Disabled buffers are seen as a constant high level.
// Assumes sync_in is already synchronized to clk.
module anport_wake #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] dig_in_en,
    input  logic [NPINS-1:0] conv_own,
    input  logic [NPINS-1:0] wken,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] flags
);
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] level_prev;
    logic [NPINS-1:0] wake_owned;
    logic [NPINS-1:0] fall;

    // Effective level seen by the detector and the ownership per pin.
    always_comb begin
        level      = sync_in | ~dig_in_en;
        wake_owned = wken & ~conv_own;
        fall       = level_prev & ~level & wake_owned;
    end

    // Previous effective level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev <= '1;
        else        level_prev <= level;
    end

    // Sticky flags: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | fall;
    end

    // R8: a flag without a clear request never drops.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((flags & $past(flags)) == $past(flags)));

    // R7: a new flag bit needs a detected falling edge behind it.
    assert_flag_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(fall)) == '0));

    // R6: a pin held by the converter never gains a flag.
    assert_conv_blocks_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & $past(conv_own)) == '0));
endmodule

// File: rtl/anport_ctrl.sv
// Top of the analog-shared GPIO port. Resolves per-pin drive, output enable
// and readback from the register file, the converter's ownership and input
// buffer masks, and the synchronized pin levels. Priority: converter, then
// wake-up, then plain GPIO. Assumes pad_in is asynchronous to clk.
module anport_ctrl #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    input  logic [NPINS-1:0] conv_own,
    input  logic [NPINS-1:0] dig_in_en,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             wake_irq
);
    import anport_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [NPINS-1:0] data_q, dir_q, wken_q, clr_mask;
    logic [NPINS-1:0] pin_sync, flags, data_rb;

    anport_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .wken_q   (wken_q),
        .clr_mask (clr_mask)
    );

    anport_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pin_sync)
    );

    anport_wake #(.NPINS(NPINS)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (pin_sync),
        .dig_in_en(dig_in_en),
        .conv_own (conv_own),
        .wken     (wken_q),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // Per-pin data readback: latch, pin level or forced high.
            always_comb begin
                if (dir_q[i])          data_rb[i] = data_q[i];
                else if (dig_in_en[i]) data_rb[i] = pin_sync[i];
                else                   data_rb[i] = 1'b1;
            end
        end
    endgenerate

    // Drive side: converter-owned pins never drive.
    always_comb begin
        pad_out  = data_q;
        pad_oe   = dir_q & ~conv_own;
        wake_irq = |(flags & wken_q);
    end

    // Register read mux.
    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_DATA:  reg_rdata = data_rb;
            RA_DIR:   reg_rdata = dir_q;
            RA_WKEN:  reg_rdata = wken_q;
            default:  reg_rdata = flags;
        endcase
    end

    // R2 / R6: after a direction write, drive follows it outside converter pins.
    assert_oe_after_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (pad_oe == ($past(reg_wdata) & ~conv_own)));

    // R1: no pin drives in the cycle after reset.
    assert_reset_no_drive_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pad_oe == '0 && !wake_irq));
endmodule

// File: tb/anport_ctrl_test.sv
module anport_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] conv_own = '0;
    logic [N-1:0] dig_in_en = '0;
    logic [N-1:0] pad_in = '1;
    logic [N-1:0] pad_out, pad_oe;
    logic         wake_irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    anport_ctrl #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_own(conv_own),
        .dig_in_en(dig_in_en), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .wake_irq(wake_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 wake_irq", wake_irq, 1'b0);
        rd(2'd1, v); check("R1 dir", v, 8'h00);
        rd(2'd2, v); check("R1 wken", v, 8'h00);
        rd(2'd3, v); check("R1 flags", v, 8'h00);
        check("R1 data latch", pad_out, 8'h00);
        rd(2'd0, v); check("R4 reset readback", v, 8'hFF);
    endtask

    task automatic t_data_dir;
        logic [N-1:0] v;
        wr(2'd0, 8'hA5);
        check("R2 latch with dir 0", pad_out, 8'hA5);
        check("R2 no drive with dir 0", pad_oe, 8'h00);
        rd(2'd0, v); check("R4 inputs read one", v, 8'hFF);
        wr(2'd1, 8'hF0);
        check("R2 oe follows dir", pad_oe, 8'hF0);
        rd(2'd1, v); check("R10 dir readback", v, 8'hF0);
        rd(2'd0, v); check("R3 mixed readback", v, 8'hAF);
        wr(2'd2, 8'h3C);
        rd(2'd2, v); check("R10 wken readback", v, 8'h3C);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_pin_read;
        logic [N-1:0] v;
        dig_in_en = 8'hFF;
        @(negedge clk);
        pad_in = 8'h3C;
        @(negedge clk);
        rd(2'd0, v); check("R5 one edge not yet", v, 8'hAF);
        @(negedge clk);
        rd(2'd0, v); check("R5 after two edges", v, 8'hAC);
        pad_in = 8'hFF;
        cyc(3);
    endtask

    task automatic t_conv;
        logic [N-1:0] v;
        conv_own = 8'h30;
        #0.5;
        check("R6 converter blocks drive", pad_oe, 8'hC0);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        conv_own = 8'h0F;
        @(negedge clk);
        pad_in = 8'h00;
        cyc(4);
        rd(2'd3, v); check("R6 converter pins no flag", v, 8'hF0);
        check("R9 irq with enabled flag", wake_irq, 1'b1);
        pad_in = 8'hFF;
        conv_own = 8'h00;
        cyc(3);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R8 clear all", v, 8'h00);
        check("R9 irq low no flags", wake_irq, 1'b0);
    endtask

    task automatic t_wake;
        logic [N-1:0] v;
        wr(2'd2, 8'h07);
        dig_in_en = 8'hFD;
        @(negedge clk);
        pad_in = 8'hF8;
        @(negedge clk);
        @(negedge clk);
        rd(2'd3, v); check("R7 not before third edge", v, 8'h00);
        @(negedge clk);
        rd(2'd3, v); check("R7 flags on fall, disabled buffer none", v, 8'h05);
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R8 write zero no effect", v, 8'h05);
        wr(2'd3, 8'h01);
        rd(2'd3, v); check("R8 write one clears", v, 8'h04);
        pad_in = 8'hFF;
        cyc(4);
        // fall at bit2 detected on the third edge; clear strobe shares it
        pad_in = 8'hFB;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd3, v); check("R8 set beats clear", v, 8'h04);
        wr(2'd3, 8'h04);
        rd(2'd3, v); check("R8 clear without edge", v, 8'h00);
        pad_in = 8'hFF;
        cyc(3);
        pad_in = 8'hFE;
        cyc(4);
        check("R9 irq on flag", wake_irq, 1'b1);
        wr(2'd2, 8'h00);
        rd(2'd3, v); check("R9 flag kept", v, 8'h01);
        check("R9 irq masked", wake_irq, 1'b0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_dir();
        t_pin_read();
        t_conv();
        t_wake();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule